// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block supplies the slow timebase of a real-time clock domain. Two oscillators feed it, both modelled as single-cycle tick pulses in the system clock domain. One is an external crystal-class source. The other is a fast internal source that a programmable prescaler divides down. The block forwards the selected timebase as a one-cycle tick for the calendar logic, and it also drives a gated copy of that tick for an output pin.

A small register port sets the block up. A change of source is requested through a control register, which refuses any write that does not carry a fixed unlock key. The divide ratio and the enable for the exported copy each have a register of their own. A requested change of source does not take effect straight away: the currently active source keeps driving until its next output tick, and only then does the new source take over. This rule prevents a shortened period on the tick stream.

Top module: `lsc_clk_select`

## Requirements
- R1: After reset the internal source is active, the requested source is internal, the divide value is 0, the output gate is off, both tick outputs are 0, and every register reads 0.
- R2: A write to the control register (address 0x00) changes the requested source (write data bit 0: 1 = external, 0 = internal) only when write data bits 31:16 equal 0x16AA. A write with any other value in those bits is ignored.
- R3: The control register reads back the requested source in bit 0 and zero in all other bits, including the key field.
- R4: The divide register at address 0x08 holds N in write data bits 4:0 and reads back N with all other bits zero.
- R5: While the internal source is active, `ls_tick` pulses for exactly one cycle per N+1 internal ticks. The first pulse comes on the (N+1)-th internal tick after the count restarts. Each pulse appears in the cycle after the clock edge that samples the causing input tick.
- R6: Writing a value of N that differs from the stored one restarts the division count from zero. Writing the same value leaves the count running.
- R7: While the external source is active, every external tick produces an `ls_tick` pulse one cycle later, whatever the value of N. Ticks from the inactive source have no effect on the outputs.
- R8: A requested change of source takes effect on the next output tick of the active source. That tick is still emitted, and `src_active` shows the new source from the same cycle. After a change to the internal source, the division count starts from zero, so no shortened period is produced.
- R9: The gate register at address 0x68-free slot 0x60 bit 0 enables `ls_out`. When the gate is on, `ls_out` equals `ls_tick`; when it is off, `ls_out` stays 0. Bit 0 reads back the gate setting.
- R10: A read from any unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| ext_tick | input | 1 | Tick pulse from the external oscillator |
| int_tick | input | 1 | Tick pulse from the internal fast oscillator |
| ls_tick | output | 1 | Selected low-speed tick, registered |
| ls_out | output | 1 | Gated copy of the low-speed tick for the output pin |
| src_active | output | 1 | Source currently driving the ticks (1 = external) |

## Verification
Both tick outputs are registered, so a pulse is due in the cycle after the edge that samples the causing input tick. A register write takes effect at the edge that samples the strobe. The bench drives every input just after a falling edge and holds it for one full cycle. It reads the outputs at the next falling edge, which falls midway between the edge that registered the result and the edge that follows. `src_active` changes on the same edge as the boundary tick, so both are checked at that one sample point. Read data is combinational and is sampled shortly after the address settles, with no strobe asserted.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int ADDR_CTRL = 'h00;
  localparam int ADDR_PRE  = 'h08;
  localparam int ADDR_GATE = 'h60;

  localparam logic [15:0] CTRL_KEY = 16'h16AA;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } lsc_src_e;

  // Unlock test on the upper half-word of a control write.
  function automatic logic key_ok(input logic [31:0] wdata);
    return wdata[31:16] == CTRL_KEY;
  endfunction

  // Divider terminal condition: count has reached the programmed N.
  function automatic logic div_due(input int unsigned cnt, input int unsigned n);
    return cnt >= n;
  endfunction

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output lsc_src_e          sel_req,
  output logic [PRE_W-1:0]  pre_n,
  output logic              pre_restart,
  output logic              gate_en
);

  logic ctrl_hit, pre_hit, gate_hit, key_match;
  logic [PRE_W-1:0] pre_new;

  assign ctrl_hit  = addr == ADDR_W'(ADDR_CTRL);
  assign pre_hit   = addr == ADDR_W'(ADDR_PRE);
  assign gate_hit  = addr == ADDR_W'(ADDR_GATE);
  assign key_match = key_ok(wdata[31:0]);
  assign pre_new   = wdata[PRE_W-1:0];

  // Restart event: only a write that really changes N.
  assign pre_restart = we && pre_hit && (pre_new != pre_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_req <= SRC_INT;
      pre_n   <= '0;
      gate_en <= 1'b0;
    end else if (we) begin
      if (ctrl_hit && key_match) sel_req <= lsc_src_e'(wdata[0]);
      if (pre_hit)               pre_n   <= pre_new;
      if (gate_hit)              gate_en <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit)      rdata[0]         = sel_req;
    else if (pre_hit)  rdata[PRE_W-1:0] = pre_n;
    else if (gate_hit) rdata[0]         = gate_en;
  end

  assert_key_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ctrl_hit && wdata[31:16] != CTRL_KEY) |=> $stable(sel_req));

  assert_pre_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && pre_hit) |=> $stable(pre_n));

endmodule

// File: rtl/lsc_prescaler.sv
module lsc_prescaler
  import lsc_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             int_tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] div_n,
  output logic             div_hit
);

  logic [PRE_W-1:0] cnt;
  logic             due;
  logic             clear;

  assign due   = div_due(32'(cnt), 32'(div_n));
  assign clear = restart || !run;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (int_tick) cnt <= due ? '0 : cnt + 1'b1;
  end

  assign div_hit = run && int_tick && !restart && due;

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_n);

endmodule

// File: rtl/lsc_src_mux.sv
module lsc_src_mux
  import lsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lsc_src_e sel_req,
  input  logic     ext_tick,
  input  logic     div_hit,
  input  logic     gate_en,
  output lsc_src_e act_src,
  output logic     run_int,
  output logic     ls_tick,
  output logic     ls_out
);

  logic boundary;
  logic switch_now;

  assign boundary   = (act_src == SRC_EXT) ? ext_tick : div_hit;
  assign switch_now = boundary && (sel_req != act_src);
  assign run_int    = act_src == SRC_INT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_src <= SRC_INT;
      ls_tick <= 1'b0;
      ls_out  <= 1'b0;
    end else begin
      if (switch_now) act_src <= sel_req;
      ls_tick <= boundary;
      ls_out  <= boundary && gate_en;
    end
  end

  assert_switch_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src != $past(act_src)) |-> ls_tick);

  assert_ext_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src == SRC_EXT && ext_tick) |=> ls_tick);

  assert_gate_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_out |-> ls_tick);

endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_tick,
  input  logic              int_tick,
  output logic              ls_tick,
  output logic              ls_out,
  output logic              src_active
);

  lsc_src_e         sel_req;
  lsc_src_e         act_src;
  logic [PRE_W-1:0] pre_n;
  logic             pre_restart;
  logic             gate_en;
  logic             run_int;
  logic             div_hit;

  lsc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk, .rst_n,
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .sel_req, .pre_n, .pre_restart, .gate_en
  );

  lsc_prescaler #(.PRE_W(PRE_W)) u_div (
    .clk, .rst_n,
    .run(run_int), .int_tick, .restart(pre_restart), .div_n(pre_n), .div_hit
  );

  lsc_src_mux u_mux (
    .clk, .rst_n,
    .sel_req, .ext_tick, .div_hit, .gate_en,
    .act_src, .run_int, .ls_tick, .ls_out
  );

  assign src_active = act_src;

endmodule

// File: tb/sim_lsc_clk_select.sv
module sim_lsc_clk_select;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_tick = 1'b0;
  logic        int_tick = 1'b0;
  logic        ls_tick, ls_out, src_active;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lsc_clk_select u0 (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ext_tick, .int_tick, .ls_tick, .ls_out, .src_active
  );

  localparam int NVEC = 6;
  localparam int VEC_N [NVEC] = '{0, 1, 2, 4, 31, 3};
  localparam int VEC_K [NVEC] = '{5, 6, 7, 10, 64, 3};
  localparam bit VEC_G [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // One tick on the chosen source; outputs sampled one cycle later.
  task automatic pulse(input bit use_ext, output bit o_ls, output bit o_out, output bit o_src);
    @(negedge clk);
    if (use_ext) ext_tick = 1'b1; else int_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0; int_tick = 1'b0;
    o_ls = ls_tick; o_out = ls_out; o_src = src_active;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit o_ls, o_out, o_src;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ls_tick", {31'b0, ls_tick}, 0);
    chk("R1 ls_out", {31'b0, ls_out}, 0);
    chk("R1 src_active", {31'b0, src_active}, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h08, d); chk("R1 pre", d, 0);
    rd(8'h60, d); chk("R1 gate", d, 0);

    // R2 wrong key ignored
    wr(8'h00, 32'h1234_0001);
    rd(8'h00, d); chk("R2 bad key readback", d, 0);
    pulse(1'b1, o_ls, o_out, o_src);
    chk("R2 bad key ext ignored", {31'b0, o_ls}, 0);
    chk("R2 bad key src", {31'b0, o_src}, 0);

    // R4 upper bits dropped
    wr(8'h08, 32'hFFFF_FFE3);
    rd(8'h08, d); chk("R4 pre readback", d, 3);
    // R10 unmapped
    rd(8'h04, d); chk("R10 unmapped 04", d, 0);
    rd(8'h64, d); chk("R10 unmapped 64", d, 0);

    // R5/R9 vector table on the internal source
    for (int v = 0; v < NVEC; v++) begin
      wr(8'h08, 32'(VEC_N[v]));
      wr(8'h60, {31'b0, VEC_G[v]});
      rd(8'h60, d); chk("R9 gate readback", d, {31'b0, VEC_G[v]});
      for (int i = 1; i <= VEC_K[v]; i++) begin
        bit exp_ls;
        exp_ls = (i % (VEC_N[v] + 1)) == 0;
        pulse(1'b0, o_ls, o_out, o_src);
        chk("R5 divided tick", {31'b0, o_ls}, {31'b0, exp_ls});
        chk("R9 gated tick", {31'b0, o_out}, {31'b0, exp_ls & VEC_G[v]});
      end
    end

    // R8 switch to external waits for internal boundary
    wr(8'h08, 32'd2);
    wr(8'h00, 32'h16AA_0001);
    rd(8'h00, d); chk("R3 ctrl readback key hidden", d, 1);
    for (int i = 0; i < 2; i++) begin
      pulse(1'b1, o_ls, o_out, o_src);
      chk("R7 ext ignored while int active", {31'b0, o_ls}, 0);
      chk("R8 still internal", {31'b0, o_src}, 0);
    end
    pulse(1'b0, o_ls, o_out, o_src); chk("R8 int 1", {31'b0, o_ls}, 0);
    pulse(1'b0, o_ls, o_out, o_src); chk("R8 int 2", {31'b0, o_ls}, 0);
    pulse(1'b0, o_ls, o_out, o_src);
    chk("R8 boundary tick emitted", {31'b0, o_ls}, 1);
    chk("R8 switched to ext", {31'b0, o_src}, 1);
    for (int i = 0; i < 2; i++) begin
      pulse(1'b1, o_ls, o_out, o_src);
      chk("R7 ext bypass", {31'b0, o_ls}, 1);
      chk("R9 ext gated", {31'b0, o_out}, 1);
    end
    pulse(1'b0, o_ls, o_out, o_src);
    chk("R7 int ignored while ext active", {31'b0, o_ls}, 0);

    // R2 wrong key while external: no switch back
    wr(8'h00, 32'h16AB_0000);
    rd(8'h00, d); chk("R2 bad key keeps ext", d, 1);

    // R8 switch back: ext boundary then full internal period
    wr(8'h00, 32'h16AA_0000);
    pulse(1'b1, o_ls, o_out, o_src);
    chk("R8 ext boundary tick", {31'b0, o_ls}, 1);
    chk("R8 switched to int", {31'b0, o_src}, 0);
    pulse(1'b0, o_ls, o_out, o_src); chk("R8 no runt 1", {31'b0, o_ls}, 0);
    pulse(1'b0, o_ls, o_out, o_src); chk("R8 no runt 2", {31'b0, o_ls}, 0);
    pulse(1'b0, o_ls, o_out, o_src); chk("R8 full period", {31'b0, o_ls}, 1);

    // R6 restart on changed N
    wr(8'h08, 32'd3);
    pulse(1'b0, o_ls, o_out, o_src);
    pulse(1'b0, o_ls, o_out, o_src);
    wr(8'h08, 32'd5);
    for (int i = 1; i <= 6; i++) begin
      pulse(1'b0, o_ls, o_out, o_src);
      chk("R6 restart count", {31'b0, o_ls}, {31'b0, i == 6});
    end
    // R6 same N: no restart
    for (int i = 0; i < 3; i++) pulse(1'b0, o_ls, o_out, o_src);
    wr(8'h08, 32'd5);
    for (int i = 1; i <= 3; i++) begin
      pulse(1'b0, o_ls, o_out, o_src);
      chk("R6 same N keeps count", {31'b0, o_ls}, {31'b0, i == 3});
    end

    // R9 gate off hides ticks on the pin
    wr(8'h60, 32'd0);
    wr(8'h08, 32'd0);
    pulse(1'b0, o_ls, o_out, o_src);
    chk("R9 gate off tick", {31'b0, o_ls}, 1);
    chk("R9 gate off pin", {31'b0, o_out}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule